// File: doc/BRIEF.md
# Serial Display Command Receiver

This block accepts write-only commands for a multiplexed display controller over three wires: a chip select, a shift clock and a data line. While chip select is high, each rising edge of the shift clock shifts one data bit into a receive register. When chip select drops, a 3-bit operation code is decoded from the last three bits of the frame. The payload is then copied into the storage that the code selects.

Storage is three segment latches, one per grid, each 56 bits wide, and one 10-bit dimming latch. All of them drive the display timing logic directly. The three serial inputs are asynchronous to the system clock. They pass through a two-flop synchronizer, and their edges are detected in the system clock domain. The shift clock therefore has to run well below the system clock.

A frame ends with its operation code, sent code bit 0 first. A segment frame has 56 payload bits followed by the code, 59 bits in all. A dimming frame has 10 payload bits followed by the code, 13 bits in all. If a frame carries more bits than its code needs, the most recent bits are the ones used.

Top module: `disp_cmd_rx`

## Requirements
- R1: After reset, all three segment outputs and the dimming output are zero.
- R2: The receiver takes in a data bit only on a rising shift clock edge while chip select is high. Shift clock edges while chip select is low leave every output unchanged.
- R3: The operation code is the last three bits of the frame, code bit 0 first. In a segment frame, the first payload bit received drives output bit 0 (segment 1) and the 56th drives bit 55. In a dimming frame, the value arrives least significant bit first.
- R4: Code 0 writes the 56-bit segment payload into all three grid latches.
- R5: Codes 1, 2 and 3 write the segment payload only into the grid 1, grid 2 and grid 3 latch respectively. The other latches keep their values.
- R6: Code 4 loads the 10-bit dimming value from a 13-bit frame. The segment latches keep their values.
- R7: A frame that ends with fewer bits than its code needs (59 for codes 0 to 3, 13 for code 4) updates no latch.
- R8: Codes 5, 6 and 7 update no latch.
- R9: Latches change only after chip select falls. A complete frame held with chip select high leaves the outputs unchanged.
- R10: When a frame carries more bits than its code needs, only the most recently received bits are used.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset that clears all registers |
| csIn | input | 1 | Chip select, asynchronous, active high |
| sclkIn | input | 1 | Shift clock, asynchronous, data taken on its rising edge |
| sdataIn | input | 1 | Serial data, asynchronous |
| grid1Seg | output | 56 | Grid 1 segment latch, bit 0 is segment 1 |
| grid2Seg | output | 56 | Grid 2 segment latch |
| grid3Seg | output | 56 | Grid 3 segment latch |
| dimLevel | output | 10 | Dimming latch |

## Verification
The assertions assume that chip select, the shift clock and the data line change slowly compared with the system clock. Each level must hold for several system cycles, so that the synchronized data bit is settled when the clock edge is detected. They also assume that chip select never changes in the same synchronized cycle as a shift clock edge. The stimulus holds every half period of the shift clock for four system cycles. It changes data only while the shift clock is low. It separates chip select edges from clock edges by at least four cycles, so none of these assumptions is broken.

// File: rtl/disp_rx_pkg.sv
package disp_rx_pkg;
  localparam int GRID_COUNT = 3;
  localparam int MODE_W = 3;

  localparam logic [MODE_W-1:0] MODE_ALL = '0;
  localparam logic [MODE_W-1:0] MODE_DIM = MODE_W'(GRID_COUNT + 1);

  typedef struct packed {
    logic                  shiftEn;
    logic [GRID_COUNT-1:0] loadSeg;
    logic                  loadDim;
  } rxStrobe_t;
endpackage

// File: rtl/disp_rx_ctrl.sv
module disp_rx_ctrl
  import disp_rx_pkg::*;
#(
  parameter int SEG_BITS    = 56,
  parameter int DIM_BITS    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csIn,
  input  logic              sclkIn,
  input  logic              sdataIn,
  input  logic [MODE_W-1:0] modeCode,
  output rxStrobe_t         stb,
  output logic              dataBit
);
  localparam int FRAME_W   = SEG_BITS + MODE_W;
  localparam int DIM_FRAME = DIM_BITS + MODE_W;
  localparam int CNT_W     = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] SEG_NEED = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] DIM_NEED = CNT_W'(DIM_FRAME);

  // synchronizer chains; the extra stage on cs and clock holds the previous level
  logic [SYNC_STAGES:0]   csPipe;
  logic [SYNC_STAGES:0]   sclkPipe;
  logic [SYNC_STAGES-1:0] dataPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe   <= '0;
      sclkPipe <= '0;
      dataPipe <= '0;
    end else begin
      csPipe   <= {csPipe[SYNC_STAGES-1:0], csIn};
      sclkPipe <= {sclkPipe[SYNC_STAGES-1:0], sclkIn};
      dataPipe <= {dataPipe[SYNC_STAGES-2:0], sdataIn};
    end
  end

  logic csNow, csPrev, csRise, csFall, sclkRise, shiftGo;
  assign csNow    = csPipe[SYNC_STAGES-1];
  assign csPrev   = csPipe[SYNC_STAGES];
  assign csRise   = csNow & ~csPrev;
  assign csFall   = ~csNow & csPrev;
  assign sclkRise = sclkPipe[SYNC_STAGES-1] & ~sclkPipe[SYNC_STAGES];
  assign shiftGo  = sclkRise & csNow;
  assign dataBit  = dataPipe[SYNC_STAGES-1];

  // saturating count of bits received in the current frame
  logic [CNT_W-1:0] bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (csRise) begin
      bitCnt <= CNT_W'(shiftGo);
    end else if (shiftGo && bitCnt != SEG_NEED) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  // decode at the synchronized falling edge of chip select
  always_comb begin
    stb         = '0;
    stb.shiftEn = shiftGo;
    if (csFall) begin
      if (modeCode == MODE_ALL) begin
        if (bitCnt >= SEG_NEED) stb.loadSeg = '1;
      end else if (modeCode == MODE_DIM) begin
        if (bitCnt >= DIM_NEED) stb.loadDim = 1'b1;
      end else begin
        for (int g = 0; g < GRID_COUNT; g++) begin
          if (modeCode == MODE_W'(g + 1) && bitCnt >= SEG_NEED) stb.loadSeg[g] = 1'b1;
        end
      end
    end
  end

  // R8
  load_mode_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadDim || (|stb.loadSeg)) |-> (modeCode <= MODE_DIM));

  // R9
  load_after_cs_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadDim || (|stb.loadSeg)) |-> (!csNow && $past(csNow)));

  // R7
  count_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    csRise |=> (bitCnt <= CNT_W'(1)));

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= SEG_NEED);
endmodule

// File: rtl/disp_rx_dp.sv
module disp_rx_dp
  import disp_rx_pkg::*;
#(
  parameter int SEG_BITS = 56,
  parameter int DIM_BITS = 10
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  rxStrobe_t                            stb,
  input  logic                                 dataBit,
  output logic [MODE_W-1:0]                    modeCode,
  output logic [GRID_COUNT-1:0][SEG_BITS-1:0] segLatch,
  output logic [DIM_BITS-1:0]                  dimLatch
);
  localparam int FRAME_W = SEG_BITS + MODE_W;

  // new bits enter at the top, so the first payload bit ends at bit 0
  // and the code sits in the top MODE_W bits whatever the frame length
  logic [FRAME_W-1:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (stb.shiftEn) shiftReg <= {dataBit, shiftReg[FRAME_W-1:1]};
  end

  assign modeCode = shiftReg[FRAME_W-1 -: MODE_W];

  for (genvar g = 0; g < GRID_COUNT; g++) begin : gGrid
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) segLatch[g] <= '0;
      else if (stb.loadSeg[g]) segLatch[g] <= shiftReg[SEG_BITS-1:0];
    end

    // R4 R5
    seg_latch_write_chk: assert property (@(posedge clk) disable iff (!rstN)
      !$stable(segLatch[g]) |-> $past(stb.loadSeg[g]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dimLatch <= '0;
    else if (stb.loadDim) dimLatch <= shiftReg[SEG_BITS-1 -: DIM_BITS];
  end

  // R2
  shift_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(shiftReg) |-> $past(stb.shiftEn));

  // R6
  dim_latch_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dimLatch) |-> $past(stb.loadDim));

  // R8
  single_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadDim, |stb.loadSeg}));
endmodule

// File: rtl/disp_cmd_rx.sv
module disp_cmd_rx
  import disp_rx_pkg::*;
#(
  parameter int SEG_BITS    = 56,
  parameter int DIM_BITS    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                csIn,
  input  logic                sclkIn,
  input  logic                sdataIn,
  output logic [SEG_BITS-1:0] grid1Seg,
  output logic [SEG_BITS-1:0] grid2Seg,
  output logic [SEG_BITS-1:0] grid3Seg,
  output logic [DIM_BITS-1:0] dimLevel
);
  rxStrobe_t                           stb;
  logic                                dataBit;
  logic [MODE_W-1:0]                   modeCode;
  logic [GRID_COUNT-1:0][SEG_BITS-1:0] segLatch;

  disp_rx_ctrl #(
    .SEG_BITS(SEG_BITS), .DIM_BITS(DIM_BITS), .SYNC_STAGES(SYNC_STAGES)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .csIn(csIn), .sclkIn(sclkIn), .sdataIn(sdataIn),
    .modeCode(modeCode), .stb(stb), .dataBit(dataBit)
  );

  disp_rx_dp #(
    .SEG_BITS(SEG_BITS), .DIM_BITS(DIM_BITS)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .dataBit(dataBit),
    .modeCode(modeCode), .segLatch(segLatch), .dimLatch(dimLevel)
  );

  assign grid1Seg = segLatch[0];
  assign grid2Seg = segLatch[1];
  assign grid3Seg = segLatch[2];
endmodule

// File: tb/disp_cmd_rx_tb_top.sv
`timescale 1ns/1ps
module disp_cmd_rx_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csIn = 1'b0;
  logic sclkIn = 1'b1;
  logic sdataIn = 1'b0;
  logic [55:0] grid1Seg, grid2Seg, grid3Seg;
  logic [9:0]  dimLevel;

  int checks = 0;
  int errors = 0;
  logic [55:0] expSeg [3];
  logic [9:0]  expDim;

  always #5 clk = ~clk;

  disp_cmd_rx dut_i (
    .clk(clk), .rstN(rstN), .csIn(csIn), .sclkIn(sclkIn), .sdataIn(sdataIn),
    .grid1Seg(grid1Seg), .grid2Seg(grid2Seg), .grid3Seg(grid3Seg), .dimLevel(dimLevel)
  );

  // entry: {code[2:0], payload bits sent[6:0], payload[55:0]}
  localparam int NVEC = 12;
  localparam logic [65:0] VEC [NVEC] = '{
    {3'd0, 7'd56, 56'hF00F0FF00F1234},
    {3'd1, 7'd56, 56'h80000000000001},
    {3'd2, 7'd56, 56'h123456789ABCDE},
    {3'd3, 7'd56, 56'hFFFFFFFFFFFFFF},
    {3'd4, 7'd10, 56'h00000000000201},
    {3'd1, 7'd40, 56'hABCDEF01234567},
    {3'd4, 7'd6,  56'h0000000000003F},
    {3'd5, 7'd56, 56'h55555555555555},
    {3'd7, 7'd10, 56'h000000000003FF},
    {3'd2, 7'd70, 56'h0F0F0F0F0F0F0F},
    {3'd4, 7'd20, 56'h00000000000155},
    {3'd3, 7'd56, 56'h00000000C0FFEE}
  };

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shiftBit(input logic b);
    sclkIn  = 1'b0;
    sdataIn = b;
    waitCyc(4);
    sclkIn = 1'b1;
    waitCyc(4);
  endtask

  // sends junk ones first when more bits are requested than needed (R10)
  task automatic sendBody(input logic [2:0] code, input int payBits, input logic [55:0] pay);
    int need = (code == 3'd4) ? 10 : 56;
    csIn = 1'b1;
    waitCyc(4);
    if (payBits > need) begin
      for (int j = 0; j < payBits - need; j++) shiftBit(1'b1);
      for (int j = 0; j < need; j++) shiftBit(pay[j]);
    end else begin
      for (int j = 0; j < payBits; j++) shiftBit(pay[j]);
    end
    for (int j = 0; j < 3; j++) shiftBit(code[j]);
    waitCyc(4);
  endtask

  task automatic endFrame;
    csIn = 1'b0;
    waitCyc(8);
  endtask

  task automatic check(input string tag, input logic [55:0] act, input logic [55:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    check(tag, grid1Seg, expSeg[0]);
    check(tag, grid2Seg, expSeg[1]);
    check(tag, grid3Seg, expSeg[2]);
    check(tag, {46'd0, dimLevel}, {46'd0, expDim});
  endtask

  function automatic string tagOf(input logic [2:0] code, input int payBits);
    int need = (code == 3'd4) ? 10 : 56;
    if (code > 3'd4) return "R8";
    if (payBits < need) return "R7";
    if (payBits > need) return "R10";
    if (code == 3'd0) return "R4";
    if (code == 3'd4) return "R6 R3";
    return "R5 R3";
  endfunction

  initial begin : watchdog
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    for (int g = 0; g < 3; g++) expSeg[g] = '0;
    expDim = '0;
    waitCyc(5);
    checkAll("R1 during reset");
    rstN = 1'b1;
    waitCyc(3);
    checkAll("R1 after reset");

    for (int i = 0; i < NVEC; i++) begin
      logic [2:0]  code = VEC[i][65:63];
      int          pb   = int'(VEC[i][62:56]);
      logic [55:0] pay  = VEC[i][55:0];
      int          need = (code == 3'd4) ? 10 : 56;
      sendBody(code, pb, pay);
      endFrame();
      if (code <= 3'd4 && pb >= need) begin
        if (code == 3'd0) for (int g = 0; g < 3; g++) expSeg[g] = pay;
        else if (code == 3'd4) expDim = pay[9:0];
        else expSeg[code - 1] = pay;
      end
      checkAll(tagOf(code, pb));
    end

    // R9: full frame held with chip select high does not load
    sendBody(3'd1, 56, 56'h13579BDF02468A);
    waitCyc(10);
    checkAll("R9 before cs falls");
    endFrame();
    expSeg[0] = 56'h13579BDF02468A;
    checkAll("R9 after cs falls");

    // R2: shift clock pulses with chip select low change nothing
    for (int j = 0; j < 20; j++) shiftBit(1'b1);
    waitCyc(6);
    checkAll("R2 clocks with cs low");
    // empty frame afterwards must not load either
    csIn = 1'b1;
    waitCyc(8);
    endFrame();
    checkAll("R2 R7 empty frame");

    // R3: dimming value least significant bit first
    sendBody(3'd4, 10, 56'h002);
    endFrame();
    expDim = 10'h002;
    checkAll("R3 dim bit order");

    // R4: broadcast clears all grids, dimming untouched
    sendBody(3'd0, 56, 56'h0);
    endFrame();
    for (int g = 0; g < 3; g++) expSeg[g] = '0;
    checkAll("R4 broadcast zero");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule